// File: doc/BRIEF.md
# Vectored Interrupt Controller for an 8-bit Core

This block collects the interrupt requests of a small 8-bit processor core and turns them into one vector at a time. Five sources feed it. The first is an external pin, which is synchronized and edge-detected. The other four are single-cycle overflow pulses from four timers. Each source has a sticky request flag and its own enable bit. A master enable gates all five sources. A stack-full input from the core blocks service while no return address can be saved.

The core reads and writes two byte-wide control registers through a plain strobe port. Requests are evaluated on every cycle in which `sample_tick` is high. That input marks the sampling phase of an instruction cycle, so requests that arrive between two ticks are judged together at the later one.

When a request is taken, the controller does three things at the same clock edge. It clears that source's flag. It clears the master enable, which turns nesting off. It presents the vector address on a valid/ready output. The vector stays on the output until the core accepts it. A return strobe that is qualified as "return with enable" sets the master enable again. A plain return leaves it alone.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, both control registers read 0x00 and `vec_valid` is low.
- R2: Control register 0 (`reg_sel`=0) holds the master enable at bit 0 and the enables for external, timer 0 and timer 1 at bits 1, 2 and 3. It holds their request flags at bits 4, 5 and 6. Bit 7 always reads 0. A write takes effect at the clock edge that samples `reg_wr`.
- R3: Control register 1 (`reg_sel`=1) holds the timer 2 and timer 3 flags at bits 0 and 1, and their enables at bits 2 and 3. Bits 7 to 4 always read 0.
- R4: With `FALL_EDGE`=1, a falling edge on `ext_pin` sets the external flag. The flag becomes readable three clock edges after the pin changes, because the pin passes two synchronizer flops and one edge flop. A rising edge sets nothing.
- R5: A one-cycle pulse on `tmr_ovf[k]` sets the flag of timer k at the next clock edge.
- R6: A request is taken only in a cycle with `sample_tick` high, its flag set, its own enable set, the master enable set, `stack_full` low and no vector held. If any one of these is missing, nothing is taken.
- R7: When several eligible requests are present together, the order of precedence from highest to lowest is external, timer 0, timer 1, timer 2, timer 3.
- R8: The vector addresses are 0x04 for external, 0x08 for timer 0, 0x0C for timer 1, 0x10 for timer 2 and 0x14 for timer 3. `vec_src` carries 0 to 4 in the same order.
- R9: Taking a request clears that source's flag and the master enable at the same clock edge. Other flags are not affected.
- R10: A `ret_strobe` cycle with `ret_sets_en`=1 sets the master enable. A `ret_strobe` cycle with `ret_sets_en`=0 leaves it unchanged.
- R11: A flag stays set until it is serviced or cleared by a register write. If a hardware set and a software clear of the same flag fall in the same cycle, the set wins.
- R12: Once raised, `vec_valid` stays high and `vec_addr`/`vec_src` stay stable until a cycle with `vec_ready` high. The vector is consumed at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 1 | External interrupt pin (asynchronous) |
| tmr_ovf | input | 4 | Overflow pulses of timers 0..3 |
| sample_tick | input | 1 | Sampling phase of the instruction cycle |
| stack_full | input | 1 | Return-address stack has no free entry |
| ret_strobe | input | 1 | A return instruction completes |
| ret_sets_en | input | 1 | Qualifies `ret_strobe` as return-with-enable |
| reg_wr | input | 1 | Control register write strobe |
| reg_sel | input | 1 | Register select: 0 = register 0, 1 = register 1 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| vec_valid | output | 1 | Vector offered to the core |
| vec_ready | input | 1 | Core accepts the vector |
| vec_addr | output | ADDR_W | Vector address |
| vec_src | output | 3 | Index of the serviced source |

## Verification
Each result has its own latency:
- A register write is visible on `reg_rdata` at the falling edge after the write cycle.
- A timer pulse shows in its flag one edge later.
- A pin edge shows in the flag three edges later, and the bench samples both the second and the third falling edge to pin that count down.
- A take happens at the first tick edge at which every condition holds, and `vec_valid` is seen at the falling edge that follows.

The scoreboard queues each expected vector before its stimulus. It pops the queue only on a falling edge where both `vec_valid` and `vec_ready` are high, so each handshake is counted exactly once.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC = 5;
  localparam int SRC_W   = $clog2(NUM_SRC);

  // register 0 layout (decoded by core software)
  localparam int R0_MASTER    = 0;
  localparam int R0_EN_BASE   = 1;
  localparam int R0_FLAG_BASE = 4;
  localparam int R0_SRCS      = 3;
  // register 1 layout
  localparam int R1_FLAG_BASE = 0;
  localparam int R1_EN_BASE   = 2;
  localparam int R1_SRCS      = NUM_SRC - R0_SRCS;

  typedef enum logic [SRC_W-1:0] {
    SRC_EXT  = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_TMR1 = 3'd2,
    SRC_TMR2 = 3'd3,
    SRC_TMR3 = 3'd4
  } src_e;
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
  parameter int SYNC_STAGES = 2,
  parameter bit FALL_EDGE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic edge_pulse
);
  localparam bit IDLE = FALL_EDGE;

  logic [SYNC_STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {(SYNC_STAGES+1){IDLE}};
    else        chain_q <= {chain_q[SYNC_STAGES-1:0], pin};
  end

  generate
    if (FALL_EDGE) begin : g_fall
      assign edge_pulse = chain_q[SYNC_STAGES] & ~chain_q[SYNC_STAGES-1];
    end else begin : g_rise
      assign edge_pulse = ~chain_q[SYNC_STAGES] & chain_q[SYNC_STAGES-1];
    end
  endgenerate

  // R4: an edge detect is a single-cycle pulse
  assert_edge_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse |=> !edge_pulse);
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               sel,
  input  logic [7:0]         wr_data,
  input  logic [NUM_SRC-1:0] hw_set,
  input  logic               ack,
  input  logic [NUM_SRC-1:0] ack_mask,
  input  logic               ret_set,
  output logic [NUM_SRC-1:0] flags,
  output logic [NUM_SRC-1:0] enables,
  output logic               master,
  output logic [7:0]         rd_data
);
  logic [NUM_SRC-1:0] flag_q, flag_d, en_q, en_d;
  logic               master_q, master_d;

  always_comb begin
    flag_d   = flag_q;
    en_d     = en_q;
    master_d = master_q;
    if (wr_en && !sel) begin
      master_d = wr_data[R0_MASTER];
      for (int i = 0; i < R0_SRCS; i++) begin
        en_d[i]   = wr_data[R0_EN_BASE + i];
        flag_d[i] = wr_data[R0_FLAG_BASE + i];
      end
    end
    if (wr_en && sel) begin
      for (int i = 0; i < R1_SRCS; i++) begin
        en_d[R0_SRCS + i]   = wr_data[R1_EN_BASE + i];
        flag_d[R0_SRCS + i] = wr_data[R1_FLAG_BASE + i];
      end
    end
    if (ret_set) master_d = 1'b1;
    if (ack) begin
      master_d = 1'b0;
      flag_d   = flag_d & ~ack_mask;
    end
    flag_d = flag_d | hw_set;   // hardware set beats any clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= '0;
      en_q     <= '0;
      master_q <= 1'b0;
    end else begin
      flag_q   <= flag_d;
      en_q     <= en_d;
      master_q <= master_d;
    end
  end

  logic [7:0] rd0, rd1;
  always_comb begin
    rd0 = '0;
    rd1 = '0;
    rd0[R0_MASTER] = master_q;
    for (int i = 0; i < R0_SRCS; i++) begin
      rd0[R0_EN_BASE + i]   = en_q[i];
      rd0[R0_FLAG_BASE + i] = flag_q[i];
    end
    for (int i = 0; i < R1_SRCS; i++) begin
      rd1[R1_EN_BASE + i]   = en_q[R0_SRCS + i];
      rd1[R1_FLAG_BASE + i] = flag_q[R0_SRCS + i];
    end
  end

  assign rd_data = sel ? rd1 : rd0;
  assign flags   = flag_q;
  assign enables = en_q;
  assign master  = master_q;

  // R11: a hardware set is always recorded
  generate
    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_chk
      assert_hw_set_sticks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set[gi] |=> flags[gi]);
    end
  endgenerate

  // R9: taking a request drops the master enable
  assert_ack_clears_master_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !master);

  // R10: return-with-enable restores the master enable
  assert_ret_sets_master_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_set && !ack) |=> master);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic          any,
  output logic [IW-1:0] win_idx
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  generate
    for (genvar gi = 0; gi < N; gi++) begin : g_chain
      assign grant[gi]  = req[gi] & ~seen[gi];
      assign seen[gi+1] = seen[gi] | req[gi];
    end
  endgenerate

  assign any = seen[N];

  always_comb begin
    win_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) win_idx = IW'(i);
    end
  end

  // R7: at most one winner, and the index matches the one-hot grant
  assert_single_winner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_index_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> grant[win_idx]);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int VEC_BASE    = 4,
  parameter int VEC_STEP    = 4,
  parameter int SYNC_STAGES = 2,
  parameter bit FALL_EDGE   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_pin,
  input  logic [3:0]        tmr_ovf,
  input  logic              sample_tick,
  input  logic              stack_full,
  input  logic              ret_strobe,
  input  logic              ret_sets_en,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              vec_valid,
  input  logic              vec_ready,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [SRC_W-1:0]  vec_src
);
  logic               ext_edge;
  logic [NUM_SRC-1:0] hw_set, flags, enables, eligible, grant, ack_mask;
  logic               master_en, any_req, take;
  logic [SRC_W-1:0]   win_idx;
  logic               valid_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [SRC_W-1:0]   src_q;

  irq_pin_edge #(.SYNC_STAGES(SYNC_STAGES), .FALL_EDGE(FALL_EDGE)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .edge_pulse(ext_edge)
  );

  assign hw_set = {tmr_ovf, ext_edge};

  irq_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr), .sel(reg_sel), .wr_data(reg_wdata),
    .hw_set(hw_set), .ack(take), .ack_mask(ack_mask),
    .ret_set(ret_strobe && ret_sets_en),
    .flags(flags), .enables(enables), .master(master_en),
    .rd_data(reg_rdata)
  );

  assign eligible = flags & enables;

  irq_prio_pick #(.N(NUM_SRC)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(eligible),
    .grant(grant), .any(any_req), .win_idx(win_idx)
  );

  assign take     = sample_tick && master_en && !stack_full && any_req && !valid_q;
  assign ack_mask = take ? grant : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      src_q   <= '0;
    end else if (take) begin
      valid_q <= 1'b1;
      addr_q  <= ADDR_W'(VEC_BASE + VEC_STEP * int'(win_idx));
      src_q   <= win_idx;
    end else if (vec_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign vec_valid = valid_q;
  assign vec_addr  = addr_q;
  assign vec_src   = src_q;

  // R6: a new vector only follows an edge with every service condition met
  assert_take_conditions_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> ($past(master_en) && !$past(stack_full) && $past(sample_tick)));

  // R12: offered vector is held until accepted
  assert_vec_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_addr) && $stable(vec_src)));

  // R10: a plain return does not touch the master enable
  assert_plain_ret_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_strobe && !ret_sets_en && !take && !reg_wr) |=> $stable(master_en));
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_pin = 1'b1;
  logic [3:0] tmr_ovf = '0;
  logic       sample_tick = 1'b1;
  logic       stack_full = 1'b0;
  logic       ret_strobe = 1'b0;
  logic       ret_sets_en = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       vec_valid;
  logic       vec_ready = 1'b1;
  logic [7:0] vec_addr;
  logic [2:0] vec_src;

  int tests = 0;
  int fails = 0;
  int hs_count = 0;
  logic [10:0] exp_q[$];   // {addr, src}

  always #(CLK_P/2) clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
    .sample_tick(sample_tick), .stack_full(stack_full),
    .ret_strobe(ret_strobe), .ret_sets_en(ret_sets_en),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_addr(vec_addr), .vec_src(vec_src)
  );

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_rd(string tag, bit sel, logic [7:0] exp);
    reg_sel = sel;
    #1;
    check(tag, int'(reg_rdata), int'(exp));
    reg_sel = 1'b0;
  endtask

  task automatic wr(bit sel, logic [7:0] data);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic pulse_tmr(logic [3:0] m);
    tmr_ovf = m;
    @(negedge clk);
    tmr_ovf = '0;
  endtask

  task automatic push_exp(logic [7:0] a, logic [2:0] s);
    exp_q.push_back({a, s});
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // monitor: one pop per accepted vector (R8, R12)
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && vec_valid && vec_ready) begin
        hs_count++;
        if (exp_q.size() == 0) begin
          check("R8 unexpected vector", int'({vec_addr, vec_src}), 0);
        end else begin
          logic [10:0] e;
          e = exp_q.pop_front();
          check("R8 vector address", int'(vec_addr), int'(e[10:3]));
          check("R7 source index", int'(vec_src), int'(e[2:0]));
        end
      end
    end
  end

  initial begin
    #(CLK_P * 50000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1
    expect_rd("R1 reg0 reset", 0, 8'h00);
    expect_rd("R1 reg1 reset", 1, 8'h00);
    #1 check("R1 vec_valid reset", int'(vec_valid), 0);
    // R2: enables on, bit 7 reads 0
    wr(0, 8'h8E);
    expect_rd("R2 reg0 layout", 0, 8'h0E);
    // R3
    wr(1, 8'hFC);
    expect_rd("R3 reg1 layout", 1, 8'h0C);
    // R5: timer 1 pulse sets bit 6
    pulse_tmr(4'b0010);
    expect_rd("R5 timer1 flag", 0, 8'h4E);
    // R6: master off -> nothing taken
    tick(3);
    #1 check("R6 master off no take", int'(vec_valid), 0);
    // R6: stack full blocks
    stack_full = 1'b1;
    wr(0, 8'h4F);
    tick(3);
    #1 check("R6 stack full no take", int'(vec_valid), 0);
    // R6: no sampling tick -> nothing taken
    stack_full = 1'b0; sample_tick = 1'b0;
    tick(3);
    #1 check("R6 no tick no take", int'(vec_valid), 0);
    // R8/R9: take timer 1
    push_exp(8'h0C, 3'd2);
    sample_tick = 1'b1;
    tick(3);
    expect_rd("R9 flag and master cleared", 0, 8'h0E);
    // R10: plain return keeps master off, return-with-enable sets it
    ret_strobe = 1'b1; ret_sets_en = 1'b0;
    tick(1);
    ret_strobe = 1'b0;
    tick(1);
    expect_rd("R10 plain return", 0, 8'h0E);
    ret_strobe = 1'b1; ret_sets_en = 1'b1;
    tick(1);
    ret_strobe = 1'b0; ret_sets_en = 1'b0;
    tick(1);
    expect_rd("R10 return with enable", 0, 8'h0F);
    // R7: all five pending at once
    wr(0, 8'h0E);
    tmr_ovf = 4'hF; ext_pin = 1'b0;
    tick(1);
    tmr_ovf = '0;
    tick(5);
    expect_rd("R4 R5 all flags reg0", 0, 8'h7E);
    expect_rd("R5 all flags reg1", 1, 8'h0F);
    push_exp(8'h04, 3'd0);
    push_exp(8'h08, 3'd1);
    push_exp(8'h0C, 3'd2);
    push_exp(8'h10, 3'd3);
    push_exp(8'h14, 3'd4);
    wr(0, 8'h7F);
    tick(4);
    for (int i = 0; i < 4; i++) begin
      ret_strobe = 1'b1; ret_sets_en = 1'b1;
      tick(1);
      ret_strobe = 1'b0; ret_sets_en = 1'b0;
      tick(4);
    end
    expect_rd("R9 all serviced reg0", 0, 8'h0E);
    expect_rd("R9 all serviced reg1", 1, 8'h0C);
    // R4: rising edge ignored, falling edge latency three edges
    ext_pin = 1'b1;
    tick(5);
    expect_rd("R4 rising edge ignored", 0, 8'h0E);
    ext_pin = 1'b0;
    tick(2);
    expect_rd("R4 flag not before third edge", 0, 8'h0E);
    tick(1);
    expect_rd("R4 flag at third edge", 0, 8'h1E);
    // R11: persistence, software clear, set beats clear
    tick(10);
    expect_rd("R11 flag persists", 0, 8'h1E);
    wr(0, 8'h0E);
    expect_rd("R11 software clear", 0, 8'h0E);
    tmr_ovf = 4'b0001;
    wr(0, 8'h0E);
    tmr_ovf = '0;
    expect_rd("R11 set beats clear", 0, 8'h2E);
    wr(0, 8'h0E);
    // R6: own enable off blocks service
    wr(1, 8'h04);
    pulse_tmr(4'b1000);
    wr(0, 8'h0F);
    tick(4);
    #1 check("R6 own enable off no take", int'(vec_valid), 0);
    expect_rd("R6 disabled flag pending", 1, 8'h06);
    wr(1, 8'h0C);
    // R12: back-pressure
    vec_ready = 1'b0;
    push_exp(8'h10, 3'd3);
    pulse_tmr(4'b0100);
    tick(1);
    tmr_ovf = 4'b0001;
    for (int i = 0; i < 4; i++) begin
      #1;
      check("R12 valid held", int'(vec_valid), 1);
      check("R12 address stable", int'(vec_addr), 8'h10);
      tick(1);
      tmr_ovf = '0;
    end
    vec_ready = 1'b1;
    tick(3);
    #1 check("R12 consumed", int'(vec_valid), 0);
    expect_rd("R12 no new take while held", 0, 8'h2E);
    expect_rd("R12 reg1 after service", 1, 8'h0C);
    check("R8 all vectors delivered", exp_q.size(), 0);
    check("R12 handshake count", hs_count, 7);
    summary();
    $finish;
  end
endmodule